// File: doc/BRIEF.md
# Serial-Addressable Attenuation Control Receiver

This block is the control front end of a digitally stepped attenuator when serial programming is selected. An external controller sends a 16-bit frame on three wires: a serial clock, a data line and a latch-enable strobe. The frame carries an attenuation word and an address word. The block captures the frame in a shift register. On the rising edge of latch enable it compares the low address bits with a 3-bit address set by board strapping. It updates its attenuation register only when the two agree. Several receivers can therefore share one serial bus, and each takes only the frames addressed to it.

All three serial wires are asynchronous to the block. Each passes through a synchronizer in the system clock domain, and the block acts on edges it detects there. The attenuation output is a 7-bit code in quarter-dB units. A flag reports a matched frame that had its reserved top data bit set. A counter shows how many bits have been shifted since the last latch.

Top module: `atten_serial_rx`

## Requirements
- R1: After reset, the attenuation code is 0x7F (maximum attenuation), the error flag is 0 and the bit count is 0.
- R2: Each rising serial-clock edge shifts one bit into the top of a 16-bit register, so the earliest bit ends in Q0. After a full frame, Q7..Q0 hold the data word (Q7 is the reserved bit D7) and Q15..Q8 hold the address word (Q10..Q8 are the compared address bits).
- R3: A serial-clock edge shifts data only while latch enable is low. Edges while latch enable is high change neither the register nor the bit count.
- R4: The attenuation code and the error flag change only as the result of a latch-enable rising edge, and never while bits are being shifted.
- R5: On a latch-enable rising edge, if Q10..Q8 equal the strapped address, Q6..Q0 are loaded as the attenuation code. Q15..Q11 are ignored.
- R6: On a latch-enable rising edge with an address mismatch, the attenuation code and the error flag keep their values.
- R7: A matched transfer with Q7 high sets the error flag and still loads Q6..Q0. A matched transfer with Q7 low clears the flag.
- R8: The bit count rises by one per shifted bit, saturates at 16 and returns to 0 on every latch-enable rising edge.
- R9: A latch-enable rising edge that arrives after fewer than 16 bits is processed on the register contents as they stand, including bits left over from the previous frame.
- R10: While the serial-select input is low, the block neither shifts nor transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel | input | 1 | High enables the serial receiver |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| latch_in | input | 1 | Latch enable, asynchronous |
| strap_addr | input | 3 | Strapped device address |
| atten_code | output | 7 | Attenuation setting in 0.25 dB steps |
| frame_err | output | 1 | Last matched frame had D7 set |
| bit_count | output | 5 | Bits shifted since the last latch, saturating |

## Verification
The assertions assume that each level on the serial wires lasts several system clocks. Every edge must pass the synchronizer and the edge detector as a single event, and data must stay steady across the sampled serial-clock edge. The strapped address and serial select are also assumed to stay constant while a frame is in flight. The stimulus holds every serial level for four system clocks, changes data only while the serial clock is low, and changes the select and strap inputs only between frames.

// File: rtl/atten_serial_rx.sv
module atten_serial_rx #(
  parameter int FRAME_BITS  = 16,
  parameter int WORD_BITS   = 8,
  parameter int ADDR_BITS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORD_BITS-2:0] RESET_CODE = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ser_sel,
  input  logic                            sclk_in,
  input  logic                            sdata_in,
  input  logic                            latch_in,
  input  logic [ADDR_BITS-1:0]            strap_addr,
  output logic [WORD_BITS-2:0]            atten_code,
  output logic                            frame_err,
  output logic [$clog2(FRAME_BITS+1)-1:0] bit_count
);
  localparam int CNT_W = $clog2(FRAME_BITS+1);
  localparam int LVL_W = WORD_BITS - 1;

  logic [SYNC_STAGES-1:0] sclk_sync, sdat_sync, le_sync;
  logic sclk_d, le_d;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sdat_sync <= '0;
      le_sync   <= '0;
      sclk_d    <= 1'b0;
      le_d      <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_in};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], sdata_in};
      le_sync   <= {le_sync[SYNC_STAGES-2:0], latch_in};
      sclk_d    <= sclk_sync[SYNC_STAGES-1];
      le_d      <= le_sync[SYNC_STAGES-1];
    end
  end

  wire sclk_now = sclk_sync[SYNC_STAGES-1];
  wire le_now   = le_sync[SYNC_STAGES-1];
  wire shift_en = ser_sel & ~le_now & sclk_now & ~sclk_d;
  wire le_rise  = ser_sel & le_now & ~le_d;
  wire addr_hit = shreg[WORD_BITS +: ADDR_BITS] == strap_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_count <= '0;
    end else if (le_rise) begin
      bit_count <= '0;
    end else if (shift_en) begin
      shreg <= {sdat_sync[SYNC_STAGES-1], shreg[FRAME_BITS-1:1]};
      if (bit_count != CNT_W'(FRAME_BITS)) bit_count <= bit_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atten_code <= RESET_CODE;
      frame_err  <= 1'b0;
    end else if (le_rise && addr_hit) begin
      atten_code <= shreg[LVL_W-1:0];
      frame_err  <= shreg[LVL_W];
    end
  end

  a_r4_hold_between_latches: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(atten_code) && $stable(frame_err));

  a_r6_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !addr_hit) |=> $stable(atten_code) && $stable(frame_err));

  a_r7_err_on_d7: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && addr_hit && shreg[LVL_W]) |=> frame_err);

  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> bit_count == '0);

  a_r8_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CNT_W'(FRAME_BITS));

  a_r3_no_shift_when_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (le_now && le_d) |=> $stable(shreg) && $stable(bit_count));

  a_r10_idle_when_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sel |=> $stable(shreg) && $stable(atten_code));
endmodule

// File: tb/atten_serial_rx_tb.sv
module atten_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, ser_sel = 1, sclk_in = 0, sdata_in = 0, latch_in = 0;
  logic [2:0] strap_addr = 3'b101;
  logic [6:0] atten_code;
  logic frame_err;
  logic [4:0] bit_count;

  atten_serial_rx u_dut (.clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .latch_in(latch_in), .strap_addr(strap_addr),
    .atten_code(atten_code), .frame_err(frame_err), .bit_count(bit_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_sh = '0;
  logic [6:0]  m_atten = 7'h7F;
  logic        m_err = 0;
  typedef struct packed { logic [6:0] a; logic e; } exp_t;
  exp_t exp_q[$];
  string exp_tag[$];

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] bits, int n, string tag);
    for (int i = 0; i < n; i++) begin
      sdata_in = bits[i];
      wait_clk(HALF);
      sclk_in = 1;
      if (ser_sel && !latch_in) m_sh = {bits[i], m_sh[15:1]};
      wait_clk(HALF);
      sclk_in = 0;
      if (i == n/2) check({tag, " R4 stable mid-shift"}, atten_code, m_atten);
    end
    wait_clk(HALF);
  endtask

  task automatic do_latch(string tag);
    latch_in = 1;
    if (ser_sel && m_sh[10:8] == strap_addr) begin
      m_atten = m_sh[6:0];
      m_err = m_sh[7];
    end
    wait_clk(HALF + 2);
    exp_q.push_back('{m_atten, m_err});
    exp_tag.push_back(tag);
    wait_clk(1);
    latch_in = 0;
    wait_clk(HALF);
  endtask

  task automatic send(logic [31:0] bits, int n, string tag);
    shift_bits(bits, n, tag);
    do_latch(tag);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      check({t, " atten"}, atten_code, e.a);
      check({t, " err"}, frame_err, e.e);
      check({t, " R8 count cleared"}, bit_count, 0);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    wait_clk(3);
    check("R1 reset atten", atten_code, 7'h7F);
    check("R1 reset err", frame_err, 0);
    check("R1 reset count", bit_count, 0);
    rst_n = 1;
    wait_clk(2);

    // R2 R5: matched, upper address bits set (ignored)
    send({16'h0, 8'hFD, 8'h49}, 16, "R2 R5 match");
    // R6: mismatch keeps 0x49
    send({16'h0, 8'h03, 8'h10}, 16, "R6 mismatch");
    // R7: D7 set loads low bits and flags
    send({16'h0, 8'h05, 8'h85}, 16, "R7 d7 set");
    send({16'h0, 8'h05, 8'h00}, 16, "R7 d7 clear");
    // R9: short frame of 8 bits, leftover address becomes data
    shift_bits(32'h0D, 8, "R9");
    check("R9 R8 count after 8 bits", bit_count, 8);
    do_latch("R9 short frame");
    // R10: serial disabled
    ser_sel = 0;
    wait_clk(2);
    send({16'h0, 8'h05, 8'h22}, 16, "R10 disabled");
    check("R10 no count", bit_count, 0);
    ser_sel = 1;
    wait_clk(2);
    // R3: clocks while latch high do nothing
    latch_in = 1;
    wait_clk(HALF + 4);
    shift_bits(32'hFFFF, 6, "R3");
    check("R3 count while latched", bit_count, 0);
    latch_in = 0;
    wait_clk(HALF);
    send({16'h0, 8'h05, 8'h7F}, 16, "R3 after latched clocks");
    // R8: long frame saturates count
    shift_bits({12'h0, 4'hA, 8'hE5, 8'h33}, 20, "R8");
    check("R8 count saturates", bit_count, 16);
    do_latch("R8 long frame");
    // different strap
    strap_addr = 3'b010;
    wait_clk(2);
    send({16'h0, 8'h02, 8'h01}, 16, "R5 new strap");
    wait_clk(10);
    wait (exp_q.size() == 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule